// File: doc/BRIEF.md
# External Bus Width Access Sequencer

This block turns CPU data accesses into bus cycles on an external memory bus where address and data share the same lines. The bus runs at a selectable width of 16 or 8 bits. Every bus cycle has the same two parts. First comes an address phase of one clock, with the address latch strobe high and the address on the shared lines. Then comes a data phase of `STB_CYC` clocks, with the read or the write strobe high. On the 8-bit bus a word access is split into two bus cycles: the low byte goes first at the even address and the high byte follows at the odd address.

Writes are posted. The single set of operation registers acts as a one-entry write buffer. A write that finds the sequencer idle is accepted in the same clock, and the CPU moves on while the bus cycles run. A read holds the CPU in stall until its data has been assembled. Any request that arrives while the sequencer is busy waits until the buffered operation is finished. The width selection is taken only at the moment a request is accepted.

The CPU keeps `cpu_req` and its fields steady until `cpu_done` is seen. `cpu_stall` is high while a request is pending and not yet done. Word addresses are expected to be even.

Top module: `ext_bus_seq`

## Requirements
- R1: With `cfg_bus8`=0, every access (byte or word) uses exactly one bus cycle. That cycle is one clock with `bus_ale`=1 and the address on `bus_ad_out`, followed by `STB_CYC` clocks of `bus_rd` or `bus_wr`.
- R2: With `cfg_bus8`=1, a word access uses two bus cycles. The first is at the even address and carries the low byte (bits 7:0 of the word) on `bus_ad_out[7:0]`/`bus_ad_in[7:0]`. The second is at the even address plus one and carries the high byte.
- R3: With `cfg_bus8`=1, a byte access uses one bus cycle at the given address, with the byte on bits 7:0 of the shared lines.
- R4: A read accepted from idle raises `cpu_done` with valid `cpu_rdata` in the last strobe clock of its last bus cycle. That is `1 + beats*(1+STB_CYC)` clocks counting the request clock, where beats is 2 for an 8-bit-bus word and 1 otherwise. Byte reads return the byte zero-extended in `cpu_rdata[7:0]`.
- R5: A write that finds the sequencer idle gets `cpu_done` in the same clock as the request, and its address phase starts in the next clock.
- R6: A read or a write that arrives while an earlier operation is still on the bus stalls until the sequencer is idle, and is then carried out normally.
- R7: `cfg_bus8` is sampled only when a request is accepted. Changing it while an operation runs does not alter that operation's number or order of bus cycles.
- R8: On the 16-bit bus, a byte at an even address uses lines 7:0 and a byte at an odd address uses lines 15:8. `bus_bhe` is high when lines 15:8 are in use (a word access or an odd byte), and it is always low on the 8-bit bus.
- R9: `bus_ale`, `bus_rd` and `bus_wr` are never high together. `bus_ad_oe` is high only in address phases and write data phases.
- R10: After reset, all bus strobes, `bus_ad_oe`, `cpu_done` and `cpu_stall` are low, and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bus8 | input | 1 | 1 selects the 8-bit bus, 0 the 16-bit bus |
| cpu_req | input | 1 | CPU access request, held until done |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_word | input | 1 | 1 word access, 0 byte access |
| cpu_addr | input | AW | Byte address |
| cpu_wdata | input | 16 | Write data (byte in bits 7:0) |
| cpu_rdata | output | 16 | Read data, valid while done is high for a read |
| cpu_done | output | 1 | Access accepted (write) or completed (read) |
| cpu_stall | output | 1 | CPU must wait |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_bhe | output | 1 | Upper lane enable on the 16-bit bus |
| bus_ad_out | output | 16 | Shared address/data lines, outgoing |
| bus_ad_oe | output | 1 | Output enable for the shared lines |
| bus_ad_in | input | 16 | Shared address/data lines, incoming |

## Verification
Random mixes of reads and writes are run over both widths, both sizes, odd and even byte addresses, and idle gaps of zero to three clocks. Requests land both on an idle sequencer and on one still busy with a posted write. Comparing the measured stall length against the computed one separates the one-beat and two-beat paths, and separates a posted write from a blocking one. Read data checked against a shadow memory exposes swapped bytes or wrong lanes. Directed cases log the order of write beats on the 8-bit bus, flip the width selection in the middle of an operation, and write odd bytes on the 16-bit bus, where the lane choice would otherwise hide.

// File: rtl/ebs_pkg.sv
// Shared types for the external bus sequencer.
package ebs_pkg;
    localparam int DW = 16;   // width of the shared address/data lines
    localparam int BW = 8;    // byte width

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_t;

    // Operation captured at accept time; doubles as the one-entry write buffer.
    typedef struct packed {
        logic          write;
        logic          word;
        logic          bus8;
        logic [DW-1:0] wdata;
    } xfer_t;
endpackage

// File: rtl/ebs_accept.sv
// CPU-side acceptance: captures one operation into the holding registers
// when the sequencer is idle and generates done/stall.
// Assumes the CPU holds its request fields steady until done is seen.
module ebs_accept
    import ebs_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic          cpu_word,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cfg_bus8,
    input  logic          seq_idle,
    input  logic          seq_finish,
    output logic          load,
    output xfer_t         xfer,
    output logic [AW-1:0] xaddr,
    output logic          cpu_done,
    output logic          cpu_stall
);

    // Accept a request only when no operation occupies the holding registers.
    always_comb load = seq_idle && cpu_req;

    // Capture the operation, including the bus width, at accept time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer  <= '0;
            xaddr <= '0;
        end else if (load) begin
            xfer.write <= cpu_we;
            xfer.word  <= cpu_word;
            xfer.bus8  <= cfg_bus8;
            xfer.wdata <= cpu_wdata;
            xaddr      <= cpu_addr;
        end
    end

    // Writes complete on acceptance; reads complete on their last strobe clock.
    always_comb begin
        cpu_done  = (load && cpu_we) || (seq_finish && !xfer.write);
        cpu_stall = cpu_req && !cpu_done;
    end

endmodule

// File: rtl/ebs_timer.sv
// Bus-cycle phase timer: one address clock, STB_CYC strobe clocks, and a
// second beat when the operation needs two bus cycles.
// Assumes load is only raised while idle.
module ebs_timer
    import ebs_pkg::*;
#(
    parameter int STB_CYC = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  logic   two_in,
    output phase_t phase,
    output logic   beat,
    output logic   strobe_last,
    output logic   finish,
    output logic   idle
);
    localparam int CW = (STB_CYC > 1) ? $clog2(STB_CYC + 1) : 1;

    phase_t phase_q;
    logic   beat_q;
    logic   two_q;

    // Strobe length: no counter needed when the data phase is a single clock.
    generate
        if (STB_CYC == 1) begin : g_single
            assign strobe_last = (phase_q == PH_DATA);
        end else begin : g_count
            logic [CW-1:0] cnt_q;
            // Count clocks spent in the data phase.
            always_ff @(posedge clk) begin
                if (!rst_n)                  cnt_q <= '0;
                else if (phase_q != PH_DATA) cnt_q <= '0;
                else                         cnt_q <= cnt_q + 1'b1;
            end
            assign strobe_last = (phase_q == PH_DATA) && (cnt_q == CW'(STB_CYC - 1));
        end
    endgenerate

    // Phase sequencing across one or two beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            beat_q  <= 1'b0;
            two_q   <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: if (load) begin
                    phase_q <= PH_ADDR;
                    beat_q  <= 1'b0;
                    two_q   <= two_in;
                end
                PH_ADDR: phase_q <= PH_DATA;
                PH_DATA: if (strobe_last) begin
                    if (!beat_q && two_q) begin
                        phase_q <= PH_ADDR;
                        beat_q  <= 1'b1;
                    end else begin
                        phase_q <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Status towards acceptance and lane logic.
    always_comb begin
        phase  = phase_q;
        beat   = beat_q;
        idle   = (phase_q == PH_IDLE);
        finish = strobe_last && (beat_q || !two_q);
    end

    // A second address phase only happens for a two-beat operation.
    assert_second_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_ADDR && beat_q) |-> $past(phase_q == PH_DATA));

endmodule

// File: rtl/ebs_lane.sv
// Lane steering: drives strobes, address and write data per beat, and
// assembles read data from one or two beats.
// Assumes word addresses are even.
module ebs_lane
    import ebs_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  xfer_t         xfer,
    input  logic [AW-1:0] xaddr,
    input  phase_t        phase,
    input  logic          beat,
    input  logic          strobe_last,
    input  logic [DW-1:0] bus_ad_in,
    output logic          bus_ale,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          bus_bhe,
    output logic [DW-1:0] bus_ad_out,
    output logic          bus_ad_oe,
    output logic [DW-1:0] cpu_rdata
);
    logic [AW-1:0] beat_addr;
    logic [DW-1:0] wr_lanes;
    logic [BW-1:0] lo_q;
    logic          split;

    // Beat address: two-beat words go even first, then odd.
    always_comb begin
        split     = xfer.bus8 && xfer.word;
        beat_addr = split ? {xaddr[AW-1:1], beat} : xaddr;
    end

    // Write data placement on the lanes.
    always_comb begin
        if (!xfer.bus8)
            wr_lanes = xfer.word ? xfer.wdata : {xfer.wdata[BW-1:0], xfer.wdata[BW-1:0]};
        else
            wr_lanes = {{BW{1'b0}}, beat ? xfer.wdata[DW-1:BW] : xfer.wdata[BW-1:0]};
    end

    // Strobes and shared-line drive per phase.
    always_comb begin
        bus_ale    = (phase == PH_ADDR);
        bus_rd     = (phase == PH_DATA) && !xfer.write;
        bus_wr     = (phase == PH_DATA) && xfer.write;
        bus_ad_oe  = bus_ale || bus_wr;
        bus_bhe    = (phase != PH_IDLE) && !xfer.bus8 && (xfer.word || xaddr[0]);
        bus_ad_out = bus_ale ? DW'(beat_addr) : (bus_wr ? wr_lanes : '0);
    end

    // Hold the low byte of a two-beat read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_q <= '0;
        else if (strobe_last && !beat && !xfer.write)
            lo_q <= bus_ad_in[BW-1:0];
    end

    // Read data assembly for each width and size.
    always_comb begin
        if (!xfer.bus8) begin
            if (xfer.word) cpu_rdata = bus_ad_in;
            else           cpu_rdata = {{BW{1'b0}}, xaddr[0] ? bus_ad_in[DW-1:BW] : bus_ad_in[BW-1:0]};
        end else begin
            if (xfer.word) cpu_rdata = {bus_ad_in[BW-1:0], lo_q};
            else           cpu_rdata = {{BW{1'b0}}, bus_ad_in[BW-1:0]};
        end
    end

    // The narrow bus never enables the upper lane.
    assert_narrow_no_bhe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ale && xfer.bus8) |-> !bus_bhe);

endmodule

// File: rtl/ext_bus_seq.sv
// External bus sequencer top: accepts CPU accesses, posts writes, and runs
// one or two multiplexed bus cycles per access on a 16- or 8-bit bus.
// Assumes STB_CYC >= 1, AW >= 2, no wait states and a single bus master.
module ext_bus_seq
    import ebs_pkg::*;
#(
    parameter int AW      = 16,
    parameter int STB_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_bus8,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic          cpu_word,
    input  logic [AW-1:0] cpu_addr,
    input  logic [15:0]   cpu_wdata,
    output logic [15:0]   cpu_rdata,
    output logic          cpu_done,
    output logic          cpu_stall,
    output logic          bus_ale,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          bus_bhe,
    output logic [15:0]   bus_ad_out,
    output logic          bus_ad_oe,
    input  logic [15:0]   bus_ad_in
);
    logic          load;
    logic          seq_idle;
    logic          seq_finish;
    logic          strobe_last;
    logic          beat;
    logic          two_in;
    phase_t        phase;
    xfer_t         xfer;
    logic [AW-1:0] xaddr;

    // Two beats are needed only for a word on the narrow bus.
    always_comb two_in = cfg_bus8 && cpu_word;

    ebs_accept #(.AW(AW)) u_accept (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_word(cpu_word),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cfg_bus8(cfg_bus8),
        .seq_idle(seq_idle), .seq_finish(seq_finish),
        .load(load), .xfer(xfer), .xaddr(xaddr),
        .cpu_done(cpu_done), .cpu_stall(cpu_stall)
    );

    ebs_timer #(.STB_CYC(STB_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .two_in(two_in),
        .phase(phase), .beat(beat), .strobe_last(strobe_last),
        .finish(seq_finish), .idle(seq_idle)
    );

    ebs_lane #(.AW(AW)) u_lane (
        .clk(clk), .rst_n(rst_n), .xfer(xfer), .xaddr(xaddr),
        .phase(phase), .beat(beat), .strobe_last(strobe_last),
        .bus_ad_in(bus_ad_in),
        .bus_ale(bus_ale), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_bhe(bus_bhe),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .cpu_rdata(cpu_rdata)
    );

    assert_ale_one_clk_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_ale);

    assert_strobe_after_ale_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rd || bus_wr) |-> $past(bus_ale));

    assert_exclusive_strobes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_ale, bus_rd, bus_wr}));

    assert_no_drive_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> !bus_ad_oe);

    assert_done_with_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> cpu_req);

    assert_post_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && cpu_we) |=> bus_ale);

endmodule

// File: tb/ext_bus_seq_test.sv
`timescale 1ns/1ps
module ext_bus_seq_test;
    localparam int STB = 2;
    localparam int P   = 1 + STB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bus8 = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_word = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic [15:0] cpu_rdata, bus_ad_out, bus_ad_in;
    logic        cpu_done, cpu_stall, bus_ale, bus_rd, bus_wr, bus_bhe, bus_ad_oe;

    always #10 clk = ~clk;

    ext_bus_seq #(.AW(16), .STB_CYC(STB)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_bus8(cfg_bus8),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_word(cpu_word),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_done(cpu_done), .cpu_stall(cpu_stall),
        .bus_ale(bus_ale), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_bhe(bus_bhe),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in)
    );

    // Behavioural external memory with address latch and write logging.
    logic [7:0] mem [0:255];
    logic [7:0] shadow [0:255];
    logic [7:0] lat_a;
    logic       wr_prev;
    int         ale_cnt;
    int         wlog_total;
    logic [7:0] wlog_a [0:3];
    logic [7:0] wlog_d [0:3];

    assign bus_ad_in = {mem[lat_a | 8'h01], bus_bhe ? mem[lat_a & 8'hFE] : mem[lat_a]};

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
            lat_a <= '0; wr_prev <= 1'b0; ale_cnt <= 0; wlog_total <= 0;
        end else begin
            wr_prev <= bus_wr;
            if (bus_ale) begin
                lat_a   <= bus_ad_out[7:0];
                ale_cnt <= ale_cnt + 1;
            end
            if (bus_wr) begin
                if (bus_bhe) begin
                    mem[lat_a | 8'h01] <= bus_ad_out[15:8];
                    if (!lat_a[0]) mem[lat_a & 8'hFE] <= bus_ad_out[7:0];
                end else begin
                    mem[lat_a] <= bus_ad_out[7:0];
                end
                if (!wr_prev) begin
                    wlog_a[wlog_total % 4] <= lat_a;
                    wlog_d[wlog_total % 4] <= bus_ad_out[7:0];
                    wlog_total <= wlog_total + 1;
                end
            end
        end
    end

    int checks = 0, failures = 0;
    int pend = 0;
    int ale_expected = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int beats_of(input bit word, input bit b8);
        return (word && b8) ? 2 : 1;
    endfunction

    function automatic int exp_cycles(input bit we, input bit word, input bit b8, input int pnd);
        return pnd + (we ? 1 : 1 + beats_of(word, b8) * P);
    endfunction

    function automatic logic [15:0] exp_read(input bit word, input logic [7:0] a);
        if (word) return {shadow[a | 8'h01], shadow[a & 8'hFE]};
        return {8'h00, shadow[a]};
    endfunction

    task automatic shadow_write(input bit word, input logic [7:0] a, input logic [15:0] d);
        if (word) begin
            shadow[a & 8'hFE] = d[7:0];
            shadow[a | 8'h01] = d[15:8];
        end else begin
            shadow[a] = d[7:0];
        end
    endtask

    // One CPU access: drives at a falling edge, waits for done, counts clocks.
    task automatic do_op(input bit we, input bit word, input bit b8,
                         input logic [7:0] a, input logic [15:0] wd,
                         output logic [15:0] rd, output int cyc);
        cfg_bus8 = b8; cpu_req = 1'b1; cpu_we = we; cpu_word = word;
        cpu_addr = {8'h00, a}; cpu_wdata = wd;
        #1;
        cyc = 1;
        while (!cpu_done) begin
            @(negedge clk); #1;
            cyc++;
        end
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    // Issue, check cycles and data, update expectations.
    task automatic run_op(input bit we, input bit word, input bit b8,
                          input logic [7:0] a, input logic [15:0] wd, input string req);
        logic [15:0] rd, expd;
        int cyc, ale0, pnd0;
        pnd0 = pend;
        ale0 = ale_cnt;
        expd = exp_read(word, a);
        do_op(we, word, b8, a, wd, rd, cyc);
        chk(cyc == exp_cycles(we, word, b8, pnd0), pnd0 > 0 ? "R6" : (we ? "R5" : "R4"),
            "stall clocks", cyc, exp_cycles(we, word, b8, pnd0));
        ale_expected += beats_of(word, b8);
        if (we) begin
            shadow_write(word, a, wd);
            pend = beats_of(word, b8) * P;
        end else begin
            chk(rd == expd, req, "read data", rd, expd);
            if (pnd0 == 0)
                chk(ale_cnt - ale0 == beats_of(word, b8), b8 ? "R2" : "R1",
                    "bus cycles", ale_cnt - ale0, beats_of(word, b8));
            pend = 0;
        end
    endtask

    task automatic drain();
        repeat (pend) @(negedge clk);
        pend = 0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = 8'(i * 7 + 3);
        repeat (4) @(negedge clk);
        // R10: reset state
        chk({bus_ale, bus_rd, bus_wr, bus_ad_oe, cpu_done, cpu_stall} == 6'b0, "R10",
            "reset outputs", {bus_ale, bus_rd, bus_wr, bus_ad_oe, cpu_done, cpu_stall}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R6: wide word write then an immediate read behind it
        run_op(1, 1, 0, 8'h10, 16'hBEEF, "R1");
        run_op(0, 1, 0, 8'h10, 16'h0000, "R6");
        run_op(0, 1, 0, 8'h10, 16'h0000, "R1");

        // R2: narrow word write, beat order and byte placement
        begin
            int w0, a0;
            w0 = wlog_total; a0 = ale_cnt;
            run_op(1, 1, 1, 8'h40, 16'hA55A, "R2");
            drain();
            chk(ale_cnt - a0 == 2, "R2", "write beats", ale_cnt - a0, 2);
            chk(wlog_a[w0 % 4] == 8'h40 && wlog_d[w0 % 4] == 8'h5A, "R2", "first beat",
                {wlog_a[w0 % 4], wlog_d[w0 % 4]}, 16'h405A);
            chk(wlog_a[(w0 + 1) % 4] == 8'h41 && wlog_d[(w0 + 1) % 4] == 8'hA5, "R2", "second beat",
                {wlog_a[(w0 + 1) % 4], wlog_d[(w0 + 1) % 4]}, 16'h41A5);
            run_op(0, 1, 1, 8'h40, 16'h0000, "R2");
        end

        // R7: width flipped while a narrow word write is on the bus
        begin
            int w0, a0;
            w0 = wlog_total; a0 = ale_cnt;
            run_op(1, 1, 1, 8'h60, 16'h1234, "R7");
            cfg_bus8 = 1'b0;
            drain();
            chk(ale_cnt - a0 == 2, "R7", "beats after width flip", ale_cnt - a0, 2);
            chk(wlog_a[(w0 + 1) % 4] == 8'h61, "R7", "second beat address",
                wlog_a[(w0 + 1) % 4], 8'h61);
            run_op(0, 1, 0, 8'h60, 16'h0000, "R7");
        end

        // R8: odd and even bytes on the wide bus
        run_op(1, 0, 0, 8'h21, 16'h00C3, "R8");
        run_op(0, 1, 0, 8'h20, 16'h0000, "R8");
        run_op(0, 0, 0, 8'h21, 16'h0000, "R8");
        run_op(1, 0, 0, 8'h24, 16'h0096, "R8");
        run_op(0, 0, 0, 8'h24, 16'h0000, "R8");

        // R3: narrow byte access at an odd address
        run_op(1, 0, 1, 8'h33, 16'h007E, "R3");
        drain();
        run_op(0, 0, 1, 8'h33, 16'h0000, "R3");

        // Random mix over both widths and sizes
        void'($urandom(32'd4711));
        for (int n = 0; n < 400; n++) begin
            bit we, word, b8;
            logic [7:0] a;
            logic [15:0] d;
            int g;
            we   = 1'($urandom);
            word = 1'($urandom);
            b8   = 1'($urandom);
            a    = 8'($urandom);
            if (word) a[0] = 1'b0;
            d    = 16'($urandom);
            run_op(we, word, b8, a, d, word ? (b8 ? "R2" : "R1") : (b8 ? "R3" : "R8"));
            g = $urandom_range(0, 3);
            repeat (g) @(negedge clk);
            pend = (pend > g) ? pend - g : 0;
        end
        drain();
        @(negedge clk);

        chk(ale_cnt == ale_expected, "R2", "total bus cycles", ale_cnt, ale_expected);
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) bad++;
            chk(bad == 0, "R2", "memory image mismatches", bad, 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R4 watchdog actual=%0h expected=%0h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule